// File: doc/BRIEF.md
# Shared Datapath Bus with Condition Flags

This block is the 16-bit shared bus of a small processor datapath. Four producers can place a word on it: the program counter, the ALU result, the memory data register and the address-mux output. Each producer has its own gate enable from the sequencer, and the bus carries the word of the single gated producer. Tri-state drivers are modelled as a masked OR of the sources, one mask per gate.

Several destination registers listen to the bus. Examples are the instruction register and the register-file write data. Each one captures the bus word only on a clock edge where its load enable is high. The block also holds the negative/zero/positive condition flags. These flags are derived from the bus word, not from the ALU output, and are reloaded only under an explicit flag-load enable.

A helper decode output tells the sequencer when the current opcode is one that should reload the flags during its writeback phase.

Top module: `bus_cc_core`

## Requirements
- R1: With exactly one gate enable high, `bus_o` equals that source's word. Gate bit 0 selects `pc_i`, bit 1 `alu_i`, bit 2 `mdr_i` and bit 3 `addr_i`.
- R2: With no gate enable high, `bus_o` is 16'h0000 and `multi_drive_o` is 0.
- R3: With two or more gate enables high, `multi_drive_o` is 1 and `bus_o` is the bitwise OR of the gated sources. With at most one gate high, `multi_drive_o` is 0.
- R4: Destination k (`dst_q_o[16k+15:16k]`) loads `bus_o` on a rising clock edge where `ld_dst_i[k]` is 1. Otherwise it keeps its value.
- R5: On a rising edge with `ld_cc_i` high, the flags `flags_o` = {N,Z,P} are reloaded from the bus word. N is set when bus bit 15 is 1. Z is set when the word is zero. P is set otherwise. Exactly one flag is set afterwards.
- R6: While `ld_cc_i` is low, `flags_o` holds its value whatever the bus carries.
- R7: `cc_load_hint_o` is 1 exactly when `wb_phase_i` is 1 and `opcode_i` is one of 4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b1010, 4'b0110 or 4'b1110. Otherwise it is 0.
- R8: While `rst_ni` is low (asynchronous, active low), `flags_o` is 3'b010 (Z only) and every destination register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | 16 | Program counter source |
| alu_i | input | 16 | ALU result source |
| mdr_i | input | 16 | Memory data register source |
| addr_i | input | 16 | Address-mux output source |
| gate_i | input | 4 | Per-source gate enables (bit0 PC, bit1 ALU, bit2 MDR, bit3 address) |
| ld_dst_i | input | 2 | Per-destination load enables |
| ld_cc_i | input | 1 | Condition-flag load enable |
| opcode_i | input | 4 | Current instruction opcode |
| wb_phase_i | input | 1 | Writeback phase indication |
| bus_o | output | 16 | Shared bus value |
| multi_drive_o | output | 1 | More than one gate enabled |
| dst_q_o | output | 32 | Destination registers, destination k in bits 16k+15:16k |
| flags_o | output | 3 | Condition flags {N,Z,P} |
| cc_load_hint_o | output | 1 | Opcode-based flag-load suggestion |

## Verification
The bound checker runs every cycle. It checks that exactly one flag is set, that the flags and the destinations hold without their load enables, and that a loaded flag Z and destination 0 match the previous bus word. It also checks that an idle bus reads zero and that a multiple-gate cycle raises the error output. The bench's scenarios are needed to show the selected word for each source and the OR value under contention. They also show the N/P split on real words, the full opcode decode, and the flag and register values forced during asynchronous reset.

// File: rtl/bus_cc_pkg.sv
package bus_cc_pkg;
  localparam int unsigned BUS_W = 16;
  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 4'b0001,
    OPC_AND = 4'b0101,
    OPC_NOT = 4'b1001,
    OPC_LD  = 4'b0010,
    OPC_LDI = 4'b1010,
    OPC_LDR = 4'b0110,
    OPC_LEA = 4'b1110
  } cc_opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/bus_src_mux.sv
module bus_src_mux #(
  parameter int unsigned W       = 16,
  parameter int unsigned NUM_SRC = 4
) (
  input  logic [NUM_SRC*W-1:0] src_i,
  input  logic [NUM_SRC-1:0]   gate_i,
  output logic [W-1:0]         bus_o,
  output logic                 multi_o
);
  logic [NUM_SRC-1:0][W-1:0] masked;

  // each gated source acts as one tri-state driver
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_drv
    assign masked[s] = src_i[s*W +: W] & {W{gate_i[s]}};
  end

  always_comb begin
    logic seen;
    bus_o   = '0;
    multi_o = 1'b0;
    seen    = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      bus_o = bus_o | masked[s];
      if (gate_i[s]) begin
        if (seen) multi_o = 1'b1;
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_dst_regs.sv
module bus_dst_regs #(
  parameter int unsigned W       = 16,
  parameter int unsigned NUM_DST = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         bus_i,
  input  logic [NUM_DST-1:0]   ld_i,
  output logic [NUM_DST*W-1:0] q_o
);
  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (ld_i[d]) q <= bus_i;
    end
    assign q_o[d*W +: W] = q;
  end
endmodule

// File: rtl/bus_cc_flags.sv
module bus_cc_flags
  import bus_cc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_i,
  input  logic         ld_i,
  output cc_t          cc_o
);
  cc_t cc_d, cc_q;

  always_comb begin
    cc_d.n = bus_i[W-1];
    cc_d.z = (bus_i == '0);
    cc_d.p = ~bus_i[W-1] & (bus_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cc_q <= CC_RESET;
    else if (ld_i) cc_q <= cc_d;
  end

  assign cc_o = cc_q;
endmodule

// File: rtl/bus_cc_decode.sv
module bus_cc_decode
  import bus_cc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             wb_phase_i,
  output logic             hint_o
);
  logic sets_cc;

  always_comb begin
    case (opcode_i)
      OPC_ADD, OPC_AND, OPC_NOT, OPC_LD,
      OPC_LDI, OPC_LDR, OPC_LEA: sets_cc = 1'b1;
      default:                   sets_cc = 1'b0;
    endcase
  end

  assign hint_o = wb_phase_i & sets_cc;
endmodule

// File: rtl/bus_cc_core.sv
module bus_cc_core
  import bus_cc_pkg::*;
#(
  parameter int unsigned W       = BUS_W,
  parameter int unsigned NUM_DST = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         pc_i,
  input  logic [W-1:0]         alu_i,
  input  logic [W-1:0]         mdr_i,
  input  logic [W-1:0]         addr_i,
  input  logic [3:0]           gate_i,
  input  logic [NUM_DST-1:0]   ld_dst_i,
  input  logic                 ld_cc_i,
  input  logic [OPC_W-1:0]     opcode_i,
  input  logic                 wb_phase_i,
  output logic [W-1:0]         bus_o,
  output logic                 multi_drive_o,
  output logic [NUM_DST*W-1:0] dst_q_o,
  output logic [2:0]           flags_o,
  output logic                 cc_load_hint_o
);
  localparam int unsigned NUM_SRC = 4;

  logic [NUM_SRC*W-1:0] src_flat;
  cc_t                  cc;

  // source index order matches gate_i bit order
  assign src_flat = {addr_i, mdr_i, alu_i, pc_i};

  bus_src_mux #(.W(W), .NUM_SRC(NUM_SRC)) u_mux (
    .src_i  (src_flat),
    .gate_i (gate_i),
    .bus_o  (bus_o),
    .multi_o(multi_drive_o)
  );

  bus_dst_regs #(.W(W), .NUM_DST(NUM_DST)) u_dst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (bus_o),
    .ld_i  (ld_dst_i),
    .q_o   (dst_q_o)
  );

  bus_cc_flags #(.W(W)) u_cc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (bus_o),
    .ld_i  (ld_cc_i),
    .cc_o  (cc)
  );

  bus_cc_decode u_dec (
    .opcode_i  (opcode_i),
    .wb_phase_i(wb_phase_i),
    .hint_o    (cc_load_hint_o)
  );

  assign flags_o = {cc.n, cc.z, cc.p};
endmodule

// File: rtl/bus_cc_chk.sv
module bus_cc_chk #(
  parameter int unsigned W       = 16,
  parameter int unsigned NUM_DST = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [3:0]           gate_i,
  input logic [NUM_DST-1:0]   ld_dst_i,
  input logic                 ld_cc_i,
  input logic [W-1:0]         bus_o,
  input logic                 multi_drive_o,
  input logic [NUM_DST*W-1:0] dst_q_o,
  input logic [2:0]           flags_o
);
  // R5
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_o) == 1);

  // R5
  flags_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cc_i |=> flags_o[1] == ($past(bus_o) == '0));

  // R6
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_cc_i |=> $stable(flags_o));

  // R4
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_dst_i == '0) |=> $stable(dst_q_o));

  // R4
  dst_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_dst_i[0] |=> dst_q_o[W-1:0] == $past(bus_o));

  // R2
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i == '0) |-> (bus_o == '0 && !multi_drive_o));

  // R3
  multi_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(gate_i) > 1) == multi_drive_o);
endmodule

bind bus_cc_core bus_cc_chk #(.W(W), .NUM_DST(NUM_DST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_i       (gate_i),
  .ld_dst_i     (ld_dst_i),
  .ld_cc_i      (ld_cc_i),
  .bus_o        (bus_o),
  .multi_drive_o(multi_drive_o),
  .dst_q_o      (dst_q_o),
  .flags_o      (flags_o)
);

// File: tb/tb_bus_cc_core.sv
module tb_bus_cc_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pc_i = 16'h3000, alu_i = 16'h8001, mdr_i = 16'h0000, addr_i = 16'h00F5;
  logic [3:0]  gate_i = '0;
  logic [1:0]  ld_dst_i = '0;
  logic        ld_cc_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic        wb_phase_i = 1'b0;
  logic [15:0] bus_o;
  logic        multi_drive_o;
  logic [31:0] dst_q_o;
  logic [2:0]  flags_o;
  logic        cc_load_hint_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  bus_cc_core dut (.*);

  // {gate, expected bus, expected flags {N,Z,P}, expected multi}
  localparam logic [23:0] VEC [7] = '{
    {4'b0001, 16'h3000, 3'b001, 1'b0},
    {4'b0010, 16'h8001, 3'b100, 1'b0},
    {4'b0100, 16'h0000, 3'b010, 1'b0},
    {4'b1000, 16'h00F5, 3'b001, 1'b0},
    {4'b0000, 16'h0000, 3'b010, 1'b0},
    {4'b0011, 16'hB001, 3'b100, 1'b1},
    {4'b1111, 16'hB0F5, 3'b100, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit sets_cc(logic [3:0] op);
    return op inside {4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b1010, 4'b0110, 4'b1110};
  endfunction

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0]  held;
    logic [15:0] d0;
    #25;
    chk("R8 reset flags", flags_o, 3'b010);
    chk("R8 reset dst", dst_q_o, 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;

    // vector table: R1 R2 R3 R5
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      gate_i = VEC[i][23:20]; ld_cc_i = 1'b1; ld_dst_i = 2'b01;
      #2;
      chk(VEC[i][0] ? "R3 bus or" : (VEC[i][23:20] == 0 ? "R2 idle bus" : "R1 bus"),
          bus_o, VEC[i][19:4]);
      chk("R3 multi", multi_drive_o, VEC[i][0]);
      @(negedge clk_i);
      ld_cc_i = 1'b0; ld_dst_i = 2'b00;
      chk("R5 flags", flags_o, VEC[i][3:1]);
      chk("R4 dst0 load", dst_q_o[15:0], VEC[i][19:4]);
    end

    // R6 hold flags, R4 hold dst0 and load dst1
    held = flags_o; d0 = dst_q_o[15:0];
    gate_i = 4'b0100;
    ld_dst_i = 2'b10;
    @(negedge clk_i);
    ld_dst_i = 2'b00;
    chk("R6 flags hold", flags_o, held);
    chk("R4 dst0 hold", dst_q_o[15:0], d0);
    chk("R4 dst1 load", dst_q_o[31:16], 16'h0000);
    gate_i = 4'b0001;
    @(negedge clk_i);
    chk("R6 flags hold P bus", flags_o, held);
    chk("R4 dst1 hold", dst_q_o[31:16], 16'h0000);

    // R5 boundary words
    alu_i = 16'h7FFF; gate_i = 4'b0010; ld_cc_i = 1'b1;
    @(negedge clk_i);
    chk("R5 max positive", flags_o, 3'b001);
    alu_i = 16'h8000;
    @(negedge clk_i);
    chk("R5 min negative", flags_o, 3'b100);
    ld_cc_i = 1'b0;

    // R7 opcode decode
    for (int op = 0; op < 16; op++) begin
      opcode_i = op[3:0];
      wb_phase_i = 1'b1;
      #1 chk("R7 hint wb", cc_load_hint_o, sets_cc(op[3:0]));
      wb_phase_i = 1'b0;
      #1 chk("R7 hint idle", cc_load_hint_o, 1'b0);
    end

    // R8 asynchronous reset mid-run
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    chk("R8 async flags", flags_o, 3'b010);
    chk("R8 async dst", dst_q_o, 32'h0);
    gate_i = 4'b0000;
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule